// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This peripheral keeps wall-clock time as a plain count of seconds. A prescaler divides the slow reference clock (nominally 32.768 kHz) by a programmable amount to make a one-second tick. Once in every 1024 tick periods it stretches that period by a programmable trim count, so that a reference that runs slightly fast can be corrected in fine steps. Each tick advances a 32-bit seconds counter, which software may also overwrite to set the time. A 32-bit alarm value is compared with the counter whenever the counter takes a new value, and a match raises a sticky alarm event.

A single status register carries two sticky event flags, one for the tick and one for the alarm, together with an interrupt enable for each. Software clears a flag by writing a one to its bit. Each interrupt output is the AND of a flag and its enable, presented from a register. Registers are reached over a simple one-cycle write strobe and a registered read path.

Top module: `rtc_seconds_top`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: The tick period is divide+1 reference cycles, where divide is bits 15:0 of the trim/divide register; a divide field of zero behaves as 32767.
- R3: The trim count in bits 25:16 of the trim/divide register is added to the period of every 1024th tick after the prescaler restarts.
- R4: Each tick adds one to the seconds counter; a bus write to the counter sets it, and a write in the same cycle as a tick wins over the increment.
- R5: Status bit 0 (alarm flag) is set whenever the counter takes a new value, by tick or by write, equal to the alarm register.
- R6: Status bit 1 (tick flag) is set on every tick.
- R7: Writing a one to status bit 0 or 1 clears that flag, writing zero leaves it; a flag that is set and cleared in the same cycle stays set.
- R8: Status bit 3 (tick enable) and bit 2 (alarm enable) are read/write; irq_tick equals bit 1 AND bit 3 and irq_alarm equals bit 0 AND bit 2.
- R9: Byte offsets: alarm 0x00, counter 0x04, trim/divide 0x08, status 0x10; read data appears the cycle after the address and unmapped offsets read zero.
- R10: Any write to the trim/divide register restarts the prescaler count and the 1024-tick trim phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that the prescaler divides |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_tick | output | 1 | Tick interrupt, tick flag AND tick enable |
| irq_alarm | output | 1 | Alarm interrupt, alarm flag AND alarm enable |

## Verification
The hardest situations to reach are the collisions of a bus write with a tick on the very same edge, and the single stretched period that comes only once every 1024 ticks. The bench makes both reachable by writing the trim/divide register, which restarts the prescaler at a known edge, and then counting cycles so that the flag clear or counter write lands exactly on the tick edge. The trim case runs a short divide for more than 1024 ticks and checks every tick spacing, with randomized divide and trim values for the ordinary spacing.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFF_ALARM   = 'h00;
  localparam int unsigned OFF_COUNT   = 'h04;
  localparam int unsigned OFF_TRIMDIV = 'h08;
  localparam int unsigned OFF_STATUS  = 'h10;

  localparam int unsigned ST_AL  = 0;
  localparam int unsigned ST_HZ  = 1;
  localparam int unsigned ST_ALE = 2;
  localparam int unsigned ST_HZE = 3;

  localparam int unsigned TRIM_LSB = 16;

  localparam int unsigned EV_AL = 0;
  localparam int unsigned EV_HZ = 1;
  localparam int unsigned NUM_EV = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned TRIM_W      = 10,
  parameter int unsigned TRIM_PERIOD = 1024,
  parameter int unsigned DEFAULT_DIV = 32767
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [DIV_W-1:0]  div,
  input  logic [TRIM_W-1:0] trim,
  output logic              tick
);
  localparam int unsigned CNT_W = DIV_W + 1;
  localparam int unsigned PH_W  = $clog2(TRIM_PERIOD);

  logic [CNT_W-1:0] pre_q;
  logic [PH_W-1:0]  phase_q;
  logic [CNT_W-1:0] div_eff;
  logic [CNT_W-1:0] limit;
  logic             long_period;

  assign div_eff     = (div == '0) ? CNT_W'(DEFAULT_DIV) : CNT_W'(div);
  assign long_period = (phase_q == PH_W'(TRIM_PERIOD - 1));
  assign limit       = div_eff + (long_period ? CNT_W'(trim) : '0);
  assign tick        = (pre_q == limit) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else if (tick) begin
      pre_q   <= '0;
      phase_q <= long_period ? '0 : phase_q + 1'b1;
    end else begin
      pre_q   <= pre_q + 1'b1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick) else $error("tick on consecutive cycles"); // R2

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick) else $error("tick right after restart"); // R10
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] seconds,
  output logic             alarm_hit
);
  logic [CNT_W-1:0] sec_q;
  logic [CNT_W-1:0] sec_nxt;
  logic             upd;

  assign upd       = wr_en || tick;
  assign sec_nxt   = wr_en ? wr_data : (tick ? sec_q + 1'b1 : sec_q);
  assign alarm_hit = upd && (sec_nxt == alarm_val);
  assign seconds   = sec_q;

  always_ff @(posedge clk) begin
    if (rst) sec_q <= '0;
    else     sec_q <= sec_nxt;
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> seconds == $past(wr_data)) else $error("counter write lost"); // R4

  AST_TICK_INC: assert property (@(posedge clk) disable iff (rst)
    tick && !wr_en |=> seconds == $past(seconds) + 1'b1) else $error("bad increment"); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick && !wr_en |=> $stable(seconds)) else $error("counter drifted"); // R4
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NUM_EV-1:0] wr_clr,
  input  logic [NUM_EV-1:0] wr_en_bits,
  input  logic [NUM_EV-1:0] ev_set,
  output logic [NUM_EV-1:0] flags,
  output logic [NUM_EV-1:0] enables,
  output logic [NUM_EV-1:0] irq
);
  logic [NUM_EV-1:0] flag_q, en_q, irq_q;
  logic [NUM_EV-1:0] flag_nxt, en_nxt;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    always_comb begin
      if (ev_set[g])                 flag_nxt[g] = 1'b1;
      else if (wr_en && wr_clr[g])   flag_nxt[g] = 1'b0;
      else                           flag_nxt[g] = flag_q[g];
      en_nxt[g] = wr_en ? wr_en_bits[g] : en_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[g] <= 1'b0;
        en_q[g]   <= 1'b0;
        irq_q[g]  <= 1'b0;
      end else begin
        flag_q[g] <= flag_nxt[g];
        en_q[g]   <= en_nxt[g];
        irq_q[g]  <= flag_nxt[g] & en_nxt[g];
      end
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
      flag_q[g] && !(wr_en && wr_clr[g]) |=> flag_q[g]) else $error("flag lost"); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      ev_set[g] |=> flag_q[g]) else $error("event missed"); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
      irq_q[g] |-> flag_q[g] && en_q[g]) else $error("irq without cause"); // R8
  end

  assign flags   = flag_q;
  assign enables = en_q;
  assign irq     = irq_q;
endmodule

// File: rtl/rtc_seconds_top.sv
module rtc_seconds_top
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned TRIM_W      = 10,
  parameter int unsigned TRIM_PERIOD = 1024,
  parameter int unsigned DEFAULT_DIV = 32767
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_tick,
  output logic              irq_alarm
);
  localparam int unsigned TRIM_MSB = TRIM_LSB + TRIM_W - 1;

  logic              sel_alarm, sel_count, sel_trimdiv, sel_status;
  logic [DATA_W-1:0] alarm_q;
  logic [DIV_W-1:0]  div_q;
  logic [TRIM_W-1:0] trim_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] seconds;
  logic              tick, alarm_hit;
  logic [NUM_EV-1:0] flags, enables, irq, ev_set, wr_clr, wr_en_bits;

  assign sel_alarm   = (bus_addr == ADDR_W'(OFF_ALARM));
  assign sel_count   = (bus_addr == ADDR_W'(OFF_COUNT));
  assign sel_trimdiv = (bus_addr == ADDR_W'(OFF_TRIMDIV));
  assign sel_status  = (bus_addr == ADDR_W'(OFF_STATUS));

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
      div_q   <= '0;
      trim_q  <= '0;
    end else if (bus_wr) begin
      if (sel_alarm) alarm_q <= bus_wdata;
      if (sel_trimdiv) begin
        div_q  <= bus_wdata[DIV_W-1:0];
        trim_q <= bus_wdata[TRIM_MSB:TRIM_LSB];
      end
    end
  end

  rtc_prescaler #(
    .DIV_W(DIV_W), .TRIM_W(TRIM_W), .TRIM_PERIOD(TRIM_PERIOD), .DEFAULT_DIV(DEFAULT_DIV)
  ) u_pre (
    .clk(clk), .rst(rst), .restart(bus_wr && sel_trimdiv),
    .div(div_q), .trim(trim_q), .tick(tick)
  );

  rtc_sec_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_en(bus_wr && sel_count), .wr_data(bus_wdata),
    .alarm_val(alarm_q), .seconds(seconds), .alarm_hit(alarm_hit)
  );

  assign ev_set[EV_AL]     = alarm_hit;
  assign ev_set[EV_HZ]     = tick;
  assign wr_clr[EV_AL]     = bus_wdata[ST_AL];
  assign wr_clr[EV_HZ]     = bus_wdata[ST_HZ];
  assign wr_en_bits[EV_AL] = bus_wdata[ST_ALE];
  assign wr_en_bits[EV_HZ] = bus_wdata[ST_HZE];

  rtc_status u_st (
    .clk(clk), .rst(rst), .wr_en(bus_wr && sel_status),
    .wr_clr(wr_clr), .wr_en_bits(wr_en_bits), .ev_set(ev_set),
    .flags(flags), .enables(enables), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_alarm)   rd_mux = alarm_q;
    if (sel_count)   rd_mux = seconds;
    if (sel_trimdiv) begin
      rd_mux[DIV_W-1:0]          = div_q;
      rd_mux[TRIM_MSB:TRIM_LSB]  = trim_q;
    end
    if (sel_status) begin
      rd_mux[ST_AL]  = flags[EV_AL];
      rd_mux[ST_HZ]  = flags[EV_HZ];
      rd_mux[ST_ALE] = enables[EV_AL];
      rd_mux[ST_HZE] = enables[EV_HZ];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_tick  = irq[EV_HZ];
  assign irq_alarm = irq[EV_AL];

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !irq_tick && !irq_alarm && bus_rdata == '0) else $error("reset state"); // R1

  AST_ALARM_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && sel_alarm) |=> $stable(alarm_q)) else $error("alarm changed"); // R9
endmodule

// File: tb/rtc_seconds_top_tb_top.sv
module rtc_seconds_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tick, irq_alarm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [4:0] A_ALARM = 5'h00, A_COUNT = 5'h04, A_TDIV = 5'h08, A_STAT = 5'h10;

  always #2.5 clk = ~clk;

  rtc_seconds_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_tick(irq_tick), .irq_alarm(irq_alarm)
  );

  function automatic logic [31:0] tdiv_word(input int d, input int t);
    return {6'b0, t[9:0], d[15:0]};
  endfunction

  function automatic logic [31:0] status_word(input bit hze, ale, hz, al);
    return {28'b0, hze, ale, hz, al};
  endfunction

  function automatic int tick_gap(input int d, input int t, input int k);
    int de = (d == 0) ? 32767 : d;
    if (k == 1) return de + 2;
    return de + 1 + ((k % 1024 == 0) ? t : 0);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic freeze();
    bus_write(A_TDIV, tdiv_word(1000, 0));
  endtask

  task automatic watch_ticks(input string req, input int d, input int t, input int nticks);
    logic [31:0] v, prev;
    int k = 0, last = 0, n = 0;
    int limit = nticks * ((d == 0 ? 32767 : d) + 2 + t) + 20;
    freeze();
    bus_write(A_COUNT, 32'h0);
    prev = 32'h0;
    bus_write(A_TDIV, tdiv_word(d, t));
    while (k < nticks && n < limit) begin
      n++;
      bus_read(A_COUNT, v);
      if (v != prev) begin
        k++;
        chk(req, $sformatf("gap of tick %0d (div %0d trim %0d)", k, d, t), n - last, tick_gap(d, t, k));
        chk("R4", "counter step", v, prev + 1);
        prev = v;
        last = n;
      end
    end
    chk(req, "ticks seen", k, nticks);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and R9 map
    chk("R1", "irq_tick", irq_tick, 0);
    chk("R1", "irq_alarm", irq_alarm, 0);
    bus_read(A_ALARM, v); chk("R1", "alarm reg", v, 0);
    bus_read(A_COUNT, v); chk("R1", "counter", v, 0);
    bus_read(A_TDIV, v);  chk("R1", "trim/div", v, 0);
    bus_read(A_STAT, v);  chk("R1", "status", v, 0);

    // R9: read back and unmapped offsets
    bus_write(A_ALARM, 32'hDEAD_BEEF);
    bus_read(A_ALARM, v); chk("R9", "alarm readback", v, 32'hDEAD_BEEF);
    bus_write(A_TDIV, 32'hFFFF_FFFF);
    bus_read(A_TDIV, v);  chk("R9", "trim/div field layout", v, tdiv_word(65535, 1023));
    bus_read(5'h0C, v);   chk("R9", "unmapped 0x0C", v, 0);
    bus_read(5'h14, v);   chk("R9", "unmapped 0x14", v, 0);

    // R2: default divide when the field is zero, R10 restart
    watch_ticks("R2", 0, 0, 1);

    // R2: random divide and trim values below the trim boundary
    for (int i = 0; i < 6; i++) begin
      int d = 1 + int'($urandom % 40);
      int t = int'($urandom % 16);
      watch_ticks("R2", d, t, 5);
    end

    // R3: trim stretches the 1024th period
    watch_ticks("R3", 3, 5, 1026);

    // R7: tick flag set and cleared on the same edge stays set
    bus_write(A_ALARM, 32'hFFFF_FFF0);
    freeze();
    bus_write(A_STAT, 32'h3);
    bus_read(A_STAT, v); chk("R7", "flags cleared", v, 0);
    bus_write(A_TDIV, tdiv_word(5, 0));
    repeat (5) @(negedge clk);
    bus_write(A_STAT, 32'h2);
    freeze();
    bus_read(A_STAT, v); chk("R7", "set wins over clear", v & 32'h2, 32'h2);

    // R4/R5: counter write on a tick edge wins, alarm matches written value
    bus_write(A_ALARM, 32'h1234);
    bus_write(A_COUNT, 32'h100);
    bus_write(A_STAT, 32'h3);
    bus_write(A_TDIV, tdiv_word(5, 0));
    repeat (5) @(negedge clk);
    bus_write(A_COUNT, 32'h1234);
    freeze();
    bus_read(A_COUNT, v); chk("R4", "write wins over tick", v, 32'h1234);
    bus_read(A_STAT, v);  chk("R5", "alarm via write", v & 32'h1, 32'h1);

    // R5/R6/R8: alarm reached by ticking, irq gating, write-zero keeps flag
    bus_write(A_ALARM, 32'h50);
    bus_write(A_COUNT, 32'h4E);
    bus_write(A_STAT, 32'h3);
    bus_write(A_TDIV, tdiv_word(2, 0));
    repeat (12) @(negedge clk);
    freeze();
    bus_read(A_STAT, v); chk("R5", "alarm via tick", v & 32'h1, 32'h1);
    chk("R6", "tick flag", v & 32'h2, 32'h2);
    chk("R8", "irq_alarm off while disabled", irq_alarm, 0);
    bus_write(A_STAT, status_word(1, 1, 0, 0));
    chk("R8", "irq_alarm enabled", irq_alarm, 1);
    chk("R8", "irq_tick enabled", irq_tick, 1);
    bus_read(A_STAT, v); chk("R7", "zero write keeps flags", v, 32'hF);
    bus_write(A_STAT, status_word(1, 1, 0, 1));
    chk("R7", "irq_alarm after clear", irq_alarm, 0);
    chk("R7", "irq_tick kept", irq_tick, 1);
    bus_write(A_STAT, status_word(1, 1, 1, 0));
    chk("R7", "irq_tick after clear", irq_tick, 0);

    // R5/R8: random counter and alarm values with random enables
    for (int i = 0; i < 16; i++) begin
      logic [31:0] cv = $urandom;
      logic [31:0] av = ($urandom % 2 == 1) ? cv : $urandom;
      bit hze = 1'($urandom), ale = 1'($urandom);
      bit al = (cv == av);
      freeze();
      bus_write(A_STAT, 32'h3);
      bus_write(A_ALARM, av);
      bus_write(A_COUNT, cv);
      bus_write(A_STAT, status_word(hze, ale, 0, 0));
      chk("R8", "random irq_alarm", irq_alarm, al & ale);
      chk("R8", "random irq_tick", irq_tick, 0);
      bus_read(A_STAT, v); chk("R5", "random status", v, status_word(hze, ale, 0, al));
      bus_read(A_COUNT, v); chk("R4", "random counter set", v, cv);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule